// File: doc/BRIEF.md
# Interrupt Collector with Input Change Detection

This block gathers eight interrupt conditions into one status byte and drives a single active-low interrupt request to a host processor. Seven of the conditions come in as one-cycle pulses from neighbouring logic, for example the receiver of the second serial channel flagging the start or end of a line break on bit 6. Each pulse latches its status bit until software clears it. The eighth condition, bit 7, is generated inside the block from four general-purpose input pins.

Each input pin passes through a two-flop synchronizer. When its synchronized level differs from the previously sampled level, a sticky delta bit is set. The deltas can be read together with the present pin levels in one byte, and reading that byte clears them. A per-pin enable nibble selects which deltas raise status bit 7. Software programs an enable mask and can read the masked status directly, which saves a read-and-AND step in the interrupt handler.

Top module: `irq_collector`

## Requirements
- R1: After reset the status, mask, change-enable and delta bits are all 0 and `irq_n` is 1.
- R2: A 1 on `src_pulse[i]` (i = 0..6) at a clock edge sets status bit i at that edge. The bit stays set until it is cleared.
- R3: A write to address 0 clears every status bit 0..6 whose `wr_data` bit is 1. If a source pulse arrives in the same cycle, the set wins. Status bit 7 cannot be cleared by this write.
- R4: Address 1 reads the status byte ANDed with the mask byte.
- R5: `irq_n` is 0 exactly while the status AND mask is nonzero, and it is updated in the same cycle as the registers.
- R6: Address 4 reads deltas in bits [7:4] and the synchronized pin levels in bits [3:0], with pin j at bits 4+j and j. A pin change made between edges shows as a level after the second edge and as a delta after the third edge.
- R7: A read strobe at address 4 clears all delta bits. A delta detected in the same cycle stays set.
- R8: Status bit 7 is 1 exactly while (deltas AND change-enable) is nonzero. The change enable is written at address 3 from `wr_data[3:0]` and reads back with bits [7:4] as 0.
- R9: The mask is written and read back at address 2. Writes to addresses 1 and 4..7 change no state, and reads at addresses 5..7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 7 | Set pulses for status bits 0..6 |
| pin_in | input | 4 | Asynchronous general-purpose inputs |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, only side effect is delta clear at address 4 |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench first uses long random runs in which source pulses, clearing writes, mask and enable writes and strobed reads at all eight addresses overlap freely. Comparing against a cycle model there separates wrong set-versus-clear priority and wrong masking from plain latching errors. Slowly toggling input pins, read at random times, show whether a delta is lost when its read-clear coincides with a new edge and whether the level-to-delta delay is correct. Directed cases force a pulse and a clear in the same cycle, write to read-only addresses, and set enable bits 7..4 to show they have no effect.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int DW  = 8,
  parameter int NIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-2:0] src_pulse,
  input  logic [NIN-1:0] pin_in,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          irq_n
);
  localparam int NSRC = DW - 1;

  logic [NSRC-1:0] stat_q;
  logic [DW-1:0]   mask_q;
  logic [NIN-1:0]  cen_q, sync1_q, sync2_q, prev_q, delta_q;
  logic [NIN-1:0]  edge_seen;
  logic [DW-1:0]   status;

  assign edge_seen = sync2_q ^ prev_q;
  assign status    = {|(delta_q & cen_q), stat_q};
  assign irq_n     = ~|(status & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      mask_q  <= '0;
      cen_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      stat_q  <= ((wr_en && addr == 3'd0) ? (stat_q & ~wr_data[NSRC-1:0]) : stat_q) | src_pulse;
      if (wr_en && addr == 3'd2) mask_q <= wr_data;
      if (wr_en && addr == 3'd3) cen_q  <= wr_data[NIN-1:0];
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      delta_q <= ((rd_en && addr == 3'd4) ? '0 : delta_q) | edge_seen;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = status;
      3'd1:    rd_data = status & mask_q;
      3'd2:    rd_data = mask_q;
      3'd3:    rd_data = DW'(cen_q);
      3'd4:    rd_data = {delta_q, sync2_q};
      default: rd_data = '0;
    endcase
  end

  // R2
  src_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(src_pulse)) == $past(src_pulse)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(src_pulse)) == '0));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> ((stat_q & $past(wr_data[NSRC-1:0] & ~src_pulse)) == '0));

  // R7
  delta_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd4 && edge_seen == '0) |=> (delta_q == '0));

  // R5
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (mask_q != '0));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd2) |=> $stable(mask_q));
endmodule

// File: tb/tb_irq_collector.sv
module tb_irq_collector;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [6:0] src_pulse = 0;
  logic [3:0] pin_in = 0;
  logic [2:0] addr = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic       rd_en = 0;
  logic [7:0] rd_data;
  logic       irq_n;

  int errors = 0;
  int checks = 0;

  logic [6:0] m_stat;
  logic [7:0] m_mask;
  logic [3:0] m_cen, m_s1, m_s2, m_prev, m_delta;

  irq_collector dut (.clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .pin_in(pin_in),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .irq_n(irq_n));

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_status();
    return {|(m_delta & m_cen), m_stat};
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return exp_status();
      3'd1: return exp_status() & m_mask;
      3'd2: return m_mask;
      3'd3: return {4'b0, m_cen};
      3'd4: return {m_delta, m_s2};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2/R3/R8 status";
      3'd1: return "R4 masked";
      3'd2: return "R9 mask";
      3'd3: return "R8 enable";
      3'd4: return "R6/R7 change";
      default: return "R9 unused";
    endcase
  endfunction

  task automatic compare_now();
    #1;
    check(req_of(addr), rd_data, exp_read(addr));
    check("R5 irq_n", {7'b0, irq_n}, {7'b0, ~|(exp_status() & m_mask)});
  endtask

  task automatic model_edge();
    logic [3:0] d;
    d = m_s2 ^ m_prev;
    m_delta = ((rd_en && addr == 3'd4) ? 4'b0 : m_delta) | d;
    m_prev = m_s2;
    m_s2 = m_s1;
    m_s1 = pin_in;
    m_stat = ((wr_en && addr == 3'd0) ? (m_stat & ~wr_data[6:0]) : m_stat) | src_pulse;
    if (wr_en && addr == 3'd2) m_mask = wr_data;
    if (wr_en && addr == 3'd3) m_cen = wr_data[3:0];
  endtask

  task automatic step();
    compare_now();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    src_pulse = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_en = 1; wr_data = d; step();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    m_stat = 0; m_mask = 0; m_cen = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_delta = 0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      check("R1 reset", rd_data, 8'h00);
    end
    check("R1 irq_n", {7'b0, irq_n}, 8'h01);
    rst_n = 1;
    @(negedge clk);

    // R9 mask readback, R8 upper enable bits dropped
    wr(3'd2, 8'hA5); addr = 3'd2; step();
    wr(3'd3, 8'hF3); addr = 3'd3; step();
    // R9 writes to read-only addresses
    wr(3'd1, 8'hFF); wr(3'd4, 8'hFF); wr(3'd6, 8'hFF);
    addr = 3'd2; step(); addr = 3'd0; step();
    // R2 pulse latch, R5 irq
    wr(3'd2, 8'h00);
    src_pulse = 7'h41; addr = 3'd0; step();
    addr = 3'd0; step();
    wr(3'd2, 8'h40); addr = 3'd1; step();
    // R3 simultaneous clear and set: set wins
    src_pulse = 7'h01; addr = 3'd0; wr_en = 1; wr_data = 8'hFF; step();
    addr = 3'd0; step();
    // R6/R8 pin change raises bit 7
    wr(3'd3, 8'h02); wr(3'd2, 8'h80);
    pin_in = 4'b0010;
    repeat (4) begin addr = 3'd4; step(); end
    addr = 3'd0; step();
    // R7 read clears deltas
    addr = 3'd4; rd_en = 1; step();
    addr = 3'd4; step();

    for (int i = 0; i < 20000; i++) begin
      r = $urandom;
      src_pulse = (r[3:0] == 0) ? 7'($urandom) : 7'h00;
      if (r[9:6] == 0) pin_in = 4'($urandom);
      addr = 3'($urandom);
      rd_en = r[10];
      wr_en = (r[15:12] < 3);
      wr_data = 8'($urandom);
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule